// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the register file of a small interrupt controller. It has `NUM_SRC` interrupt sources and `NUM_CTX` target contexts. A 32-bit register port issues word accesses. The block decodes each one into one of three address regions and keeps the programmable state that the selection logic needs:

- one priority value for each source;
- one enable bit for each source in each context;
- one priority threshold for each context.

This state is presented on flat output buses. The claim/complete location of each context holds no state. A read there returns the winning source ID that the external selector supplies for that context, and raises a one-cycle claim strobe. A write there raises a one-cycle complete strobe that carries the written source ID.

The map is fixed and sparse:

| Region | Base (byte address) | Stride | Registers |
|---|---|---|---|
| Priority | 0x000000 | 4 bytes per source | one priority per source |
| Enable | 0x002000 | 0x80 bytes per context | 32 sources per word |
| Context control | 0x200000 | 0x1000 bytes per context | threshold at +0, claim/complete at +4 |

The request side is always ready. Every accepted access produces a one-cycle response on the cycle after it is accepted.

Top module: `irqc_regfile`

## Requirements
- R1: After reset, every priority, enable bit and threshold is zero, no strobe is raised and `rsp_valid` is low.
- R2: A write to byte address 4*i with 1 <= i < NUM_SRC stores the low PRIO_W bits of the data as the priority of source i. A read of that address returns the stored value zero-extended.
- R3: The priority of source 0 and of sources i >= NUM_SRC cannot be written, and reads of those addresses return zero.
- R4: Each context has a block of enable words at 0x2000 + 0x80*c + 4*w, for w < ceil(NUM_SRC/32). Bit b of word w is the enable of source 32*w+b for context c. Bits for sources >= NUM_SRC always read back as zero.
- R5: The enable bit of source 0 (bit 0 of word 0) is always zero, whatever is written.
- R6: The threshold of context c is at 0x200000 + 0x1000*c. A written value is first masked to its low PRIO_W bits. If the masked value is greater than MAX_PRIO, the stored threshold is left unchanged; otherwise it is stored.
- R7: A read of 0x200004 + 0x1000*c returns the `claim_id` slice of context c, sampled when the request is accepted. It raises `claim_rd[c]` for one cycle together with `rsp_valid`.
- R8: A write of 0x200004 + 0x1000*c raises `complete_wr[c]` for one cycle together with `rsp_valid`. It drives the low ID_W data bits on `complete_id` and changes no stored state.
- R9: Any access to a context index c >= NUM_CTX, in either per-context region, has no effect, raises no strobe and reads zero.
- R10: Address bits [1:0] are ignored.
- R11: Every other location reads zero and ignores writes. This covers 0x1000-0x1FFF, enable words past the last one, and context offsets other than +0 and +4.
- R12: `req_ready` is always high. Each accepted request gives exactly one `rsp_valid` pulse on the next cycle. Read data is valid with that pulse, and write responses carry zero data. A register write is visible on the state outputs from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address inside the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| claim_id | input | NUM_CTX*ID_W | Current best source ID per context, from the selector |
| prio_flat | output | NUM_SRC*PRIO_W | Source priorities, source i at [i*PRIO_W +: PRIO_W] |
| enable_flat | output | NUM_CTX*NUM_SRC | Enables, context c source i at bit c*NUM_SRC+i |
| thresh_flat | output | NUM_CTX*PRIO_W | Context thresholds |
| claim_rd | output | NUM_CTX | Claim read strobe per context |
| complete_wr | output | NUM_CTX | Complete write strobe per context |
| complete_id | output | ID_W | Source ID carried by a complete write |

## Verification
The bench targets the corner cases of address decoding and value filtering:

- **Source 0.** The bench writes all-ones to source 0's priority and to enable word 0. A design that does not force source 0 to zero would show a live enable bit or a nonzero priority there.
- **Sources past NUM_SRC.** The bench writes all-ones to the partially used last enable word. A decoder that lets bits past NUM_SRC through would read back extra set bits.
- **Threshold filter.** The bench writes threshold values above MAX_PRIO, both before and after masking to PRIO_W bits. A design that compares before masking, or that saturates instead of rejecting, returns the wrong threshold.
- **Address edges.** The bench accesses context indices one past the end, the reserved pending area, unused context offsets and addresses with nonzero low bits. A design that aliases these would corrupt a live register or raise a stray claim or complete strobe.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word-address (byte address >> 2) width and region bases
    localparam int unsigned WA_W        = 22;
    localparam logic [WA_W-1:0] EN_BASE_WA  = 22'h000800;   // byte 0x002000
    localparam logic [WA_W-1:0] CTX_BASE_WA = 22'h080000;   // byte 0x200000
    localparam int unsigned EN_STRIDE_LG  = 5;              // 0x80 bytes per context
    localparam int unsigned CTX_STRIDE_LG = 10;             // 0x1000 bytes per context
    localparam logic [WA_W-1:0] OFF_THRESH = 22'd0;
    localparam logic [WA_W-1:0] OFF_CLAIM  = 22'd1;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_PRIO,
        RGN_ENABLE,
        RGN_THRESH,
        RGN_CLAIM
    } rgn_e;

    typedef struct packed {
        rgn_e            rgn;
        logic [WA_W-1:0] ctx;   // context index (enable / control regions)
        logic [WA_W-1:0] idx;   // source index (priority) or word index (enable)
    } dec_t;

    // Number of 32-bit enable words per context
    function automatic int unsigned words_for(input int unsigned nsrc);
        return (nsrc + 31) / 32;
    endfunction

    // True when the global enable bit is backed by storage
    function automatic bit en_bit_live(input int unsigned gbit, input int unsigned nsrc);
        return (gbit != 0) && (gbit < nsrc);
    endfunction

endpackage

// File: rtl/irqc_addr_decode.sv
module irqc_addr_decode
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 40,
    parameter int unsigned NUM_CTX   = 3,
    parameter int unsigned NUM_WORDS = 2
) (
    input  logic [WA_W-1:0] word_addr,
    output dec_t            dec
);

    localparam logic [WA_W-1:0] SRC_LIM  = WA_W'(NUM_SRC);
    localparam logic [WA_W-1:0] CTX_LIM  = WA_W'(NUM_CTX);
    localparam logic [WA_W-1:0] WORD_LIM = WA_W'(NUM_WORDS);

    logic [WA_W-1:0] en_off;
    logic [WA_W-1:0] cc_off;
    logic [WA_W-1:0] en_ctx;
    logic [WA_W-1:0] en_word;
    logic [WA_W-1:0] cc_ctx;
    logic [WA_W-1:0] cc_reg;

    always_comb begin
        en_off  = word_addr - EN_BASE_WA;
        cc_off  = word_addr - CTX_BASE_WA;
        en_ctx  = en_off >> EN_STRIDE_LG;
        en_word = en_off & WA_W'((1 << EN_STRIDE_LG) - 1);
        cc_ctx  = cc_off >> CTX_STRIDE_LG;
        cc_reg  = cc_off & WA_W'((1 << CTX_STRIDE_LG) - 1);
    end

    always_comb begin
        dec.rgn = RGN_NONE;
        dec.ctx = '0;
        dec.idx = '0;
        if (word_addr < EN_BASE_WA) begin
            if (word_addr != '0 && word_addr < SRC_LIM) begin
                dec.rgn = RGN_PRIO;
                dec.idx = word_addr;
            end
        end else if (word_addr < CTX_BASE_WA) begin
            if (en_ctx < CTX_LIM && en_word < WORD_LIM) begin
                dec.rgn = RGN_ENABLE;
                dec.ctx = en_ctx;
                dec.idx = en_word;
            end
        end else begin
            if (cc_ctx < CTX_LIM) begin
                dec.ctx = cc_ctx;
                if (cc_reg == OFF_THRESH)
                    dec.rgn = RGN_THRESH;
                else if (cc_reg == OFF_CLAIM)
                    dec.rgn = RGN_CLAIM;
            end
        end
    end

endmodule

// File: rtl/irqc_prio_bank.sv
module irqc_prio_bank
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned PRIO_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [WA_W-1:0]             wr_idx,
    input  logic [PRIO_W-1:0]           wr_val,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat
);

    // Source 0 has no storage; every other source owns one register.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s == 0) begin : g_none
            assign prio_flat[s*PRIO_W +: PRIO_W] = '0;
        end else begin : g_reg
            logic [PRIO_W-1:0] prio_q;
            always_ff @(posedge clk) begin
                if (rst)
                    prio_q <= '0;
                else if (wr_en && wr_idx == WA_W'(s))
                    prio_q <= wr_val;
            end
            assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q;
        end
    end

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 40,
    parameter int unsigned NUM_CTX   = 3,
    parameter int unsigned NUM_WORDS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [WA_W-1:0]                   wr_ctx,
    input  logic [WA_W-1:0]                   wr_word,
    input  logic [31:0]                       wr_data,
    output logic [NUM_CTX*NUM_WORDS*32-1:0]   en_words
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            logic word_sel;
            assign word_sel = wr_en && wr_ctx == WA_W'(c) && wr_word == WA_W'(w);
            for (genvar b = 0; b < 32; b++) begin : g_bit
                localparam int unsigned GBIT = w * 32 + b;
                localparam int unsigned POS  = (c * NUM_WORDS + w) * 32 + b;
                if (en_bit_live(GBIT, NUM_SRC)) begin : g_live
                    logic en_q;
                    always_ff @(posedge clk) begin
                        if (rst)
                            en_q <= 1'b0;
                        else if (word_sel)
                            en_q <= wr_data[b];
                    end
                    assign en_words[POS] = en_q;
                end else begin : g_tied
                    assign en_words[POS] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/irqc_ctx_ctrl.sv
module irqc_ctx_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_CTX  = 3,
    parameter int unsigned PRIO_W   = 4,
    parameter int unsigned MAX_PRIO = 7,
    parameter int unsigned ID_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        thr_we,
    input  logic                        claim_re,
    input  logic                        cmpl_we,
    input  logic [WA_W-1:0]             sel_ctx,
    input  logic [PRIO_W-1:0]           thr_val,
    input  logic [ID_W-1:0]             cmpl_val,
    output logic [NUM_CTX*PRIO_W-1:0]   thresh_flat,
    output logic [NUM_CTX-1:0]          claim_rd,
    output logic [NUM_CTX-1:0]          complete_wr,
    output logic [ID_W-1:0]             complete_id
);

    localparam logic [PRIO_W-1:0] PRIO_CAP = PRIO_W'(MAX_PRIO);

    logic thr_ok;
    assign thr_ok = (thr_val <= PRIO_CAP);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [PRIO_W-1:0] thr_q;
        logic              hit;
        assign hit = (sel_ctx == WA_W'(c));

        always_ff @(posedge clk) begin
            if (rst)
                thr_q <= '0;
            else if (thr_we && hit && thr_ok)
                thr_q <= thr_val;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                claim_rd[c]    <= 1'b0;
                complete_wr[c] <= 1'b0;
            end else begin
                claim_rd[c]    <= claim_re && hit;
                complete_wr[c] <= cmpl_we && hit;
            end
        end

        assign thresh_flat[c*PRIO_W +: PRIO_W] = thr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            complete_id <= '0;
        else if (cmpl_we)
            complete_id <= cmpl_val;
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 40,
    parameter int unsigned NUM_CTX  = 3,
    parameter int unsigned PRIO_W   = 4,
    parameter int unsigned MAX_PRIO = 7,
    parameter int unsigned ID_W     = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [23:0]                 req_addr,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    input  logic [NUM_CTX*ID_W-1:0]     claim_id,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    output logic [NUM_CTX*NUM_SRC-1:0]  enable_flat,
    output logic [NUM_CTX*PRIO_W-1:0]   thresh_flat,
    output logic [NUM_CTX-1:0]          claim_rd,
    output logic [NUM_CTX-1:0]          complete_wr,
    output logic [ID_W-1:0]             complete_id
);

    localparam int unsigned NUM_WORDS = words_for(NUM_SRC);

    logic [NUM_CTX*NUM_WORDS*32-1:0] en_words;
    dec_t  dec;
    logic  acc;
    logic  unused_byte_lane;
    logic [31:0] rd_next;

    assign req_ready        = 1'b1;
    assign acc              = req_valid && req_ready;
    assign unused_byte_lane = ^req_addr[1:0];

    irqc_addr_decode #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CTX  (NUM_CTX),
        .NUM_WORDS(NUM_WORDS)
    ) u_dec (
        .word_addr(req_addr[23:2]),
        .dec      (dec)
    );

    irqc_prio_bank #(
        .NUM_SRC(NUM_SRC),
        .PRIO_W (PRIO_W)
    ) u_prio (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc && req_write && dec.rgn == RGN_PRIO),
        .wr_idx   (dec.idx),
        .wr_val   (req_wdata[PRIO_W-1:0]),
        .prio_flat(prio_flat)
    );

    irqc_enable_bank #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CTX  (NUM_CTX),
        .NUM_WORDS(NUM_WORDS)
    ) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc && req_write && dec.rgn == RGN_ENABLE),
        .wr_ctx  (dec.ctx),
        .wr_word (dec.idx),
        .wr_data (req_wdata),
        .en_words(en_words)
    );

    irqc_ctx_ctrl #(
        .NUM_CTX (NUM_CTX),
        .PRIO_W  (PRIO_W),
        .MAX_PRIO(MAX_PRIO),
        .ID_W    (ID_W)
    ) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .thr_we     (acc && req_write && dec.rgn == RGN_THRESH),
        .claim_re   (acc && !req_write && dec.rgn == RGN_CLAIM),
        .cmpl_we    (acc && req_write && dec.rgn == RGN_CLAIM),
        .sel_ctx    (dec.ctx),
        .thr_val    (req_wdata[PRIO_W-1:0]),
        .cmpl_val   (req_wdata[ID_W-1:0]),
        .thresh_flat(thresh_flat),
        .claim_rd   (claim_rd),
        .complete_wr(complete_wr),
        .complete_id(complete_id)
    );

    // Repack enable words into the per-source output bus
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_en_out
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign enable_flat[c*NUM_SRC + s] = en_words[c*NUM_WORDS*32 + s];
        end
    end

    // Read data selection
    always_comb begin
        rd_next = '0;
        unique case (dec.rgn)
            RGN_PRIO: begin
                for (int s = 1; s < NUM_SRC; s++)
                    if (dec.idx == WA_W'(s))
                        rd_next = 32'(prio_flat[s*PRIO_W +: PRIO_W]);
            end
            RGN_ENABLE: begin
                for (int c = 0; c < NUM_CTX; c++)
                    for (int w = 0; w < NUM_WORDS; w++)
                        if (dec.ctx == WA_W'(c) && dec.idx == WA_W'(w))
                            rd_next = en_words[(c*NUM_WORDS + w)*32 +: 32];
            end
            RGN_THRESH: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (dec.ctx == WA_W'(c))
                        rd_next = 32'(thresh_flat[c*PRIO_W +: PRIO_W]);
            end
            RGN_CLAIM: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (dec.ctx == WA_W'(c))
                        rd_next = 32'(claim_id[c*ID_W +: ID_W]);
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc;
            rsp_rdata <= (acc && !req_write) ? rd_next : 32'd0;
        end
    end

endmodule

// File: rtl/irqc_regfile_chk.sv
module irqc_regfile_chk #(
    parameter int unsigned NUM_SRC  = 40,
    parameter int unsigned NUM_CTX  = 3,
    parameter int unsigned PRIO_W   = 4,
    parameter int unsigned MAX_PRIO = 7
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic                        req_write,
    input logic                        rsp_valid,
    input logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    input logic [NUM_CTX*NUM_SRC-1:0]  enable_flat,
    input logic [NUM_CTX*PRIO_W-1:0]   thresh_flat,
    input logic [NUM_CTX-1:0]          claim_rd,
    input logic [NUM_CTX-1:0]          complete_wr
);

    AST_SRC0_PRIO_ZERO: assert property (@(posedge clk) disable iff (rst)
        prio_flat[PRIO_W-1:0] == '0);                                          // R3

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        AST_SRC0_EN_ZERO: assert property (@(posedge clk) disable iff (rst)
            !enable_flat[c*NUM_SRC]);                                          // R5
        AST_THRESH_BOUND: assert property (@(posedge clk) disable iff (rst)
            thresh_flat[c*PRIO_W +: PRIO_W] <= PRIO_W'(MAX_PRIO));             // R6
    end

    AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_rd));                                                   // R7
    AST_STROBE_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        (|claim_rd || |complete_wr) |-> rsp_valid);                            // R7
    AST_COMPLETE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(complete_wr));                                                // R8
    AST_COMPLETE_NO_STATE: assert property (@(posedge clk) disable iff (rst)
        |complete_wr |-> ($stable(prio_flat) && $stable(enable_flat) && $stable(thresh_flat))); // R8
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);                               // R12
    AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));                          // R12
    AST_STATE_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> ($stable(prio_flat) && $stable(enable_flat) && $stable(thresh_flat))); // R12

endmodule

bind irqc_regfile irqc_regfile_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W),
    .MAX_PRIO(MAX_PRIO)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .prio_flat  (prio_flat),
    .enable_flat(enable_flat),
    .thresh_flat(thresh_flat),
    .claim_rd   (claim_rd),
    .complete_wr(complete_wr)
);

// File: tb/irqc_regfile_tb.sv
`timescale 1ns/1ps
module irqc_regfile_tb;

    localparam int NS   = 40;
    localparam int NC   = 3;
    localparam int PW   = 4;
    localparam int MAXP = 7;
    localparam int IW   = 6;
    localparam int NW   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NC*IW-1:0] claim_id = '0;
    logic [NS*PW-1:0] prio_flat;
    logic [NC*NS-1:0] enable_flat;
    logic [NC*PW-1:0] thresh_flat;
    logic [NC-1:0] claim_rd;
    logic [NC-1:0] complete_wr;
    logic [IW-1:0] complete_id;

    always #2 clk = ~clk;

    irqc_regfile u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .claim_id(claim_id),
        .prio_flat(prio_flat), .enable_flat(enable_flat), .thresh_flat(thresh_flat),
        .claim_rd(claim_rd), .complete_wr(complete_wr), .complete_id(complete_id)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [PW-1:0] prio_m [NS];
    logic [31:0]   en_m   [NC][NW];
    logic [PW-1:0] thr_m  [NC];

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_mask(input int w);
        logic [31:0] m = '0;
        for (int b = 0; b < 32; b++)
            if (w*32+b != 0 && w*32+b < NS) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [255:0] prio_exp();
        logic [255:0] v = '0;
        for (int s = 0; s < NS; s++) v[s*PW +: PW] = prio_m[s];
        return v;
    endfunction

    function automatic logic [255:0] en_exp();
        logic [255:0] v = '0;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) v[c*NS+s] = en_m[c][s/32][s%32];
        return v;
    endfunction

    function automatic logic [255:0] thr_exp();
        logic [255:0] v = '0;
        for (int c = 0; c < NC; c++) v[c*PW +: PW] = thr_m[c];
        return v;
    endfunction

    // Reference map from the requirements: returns read data, strobe expectations,
    // and applies a write to the model.
    task automatic ref_access(input bit wr, input logic [23:0] addr, input logic [31:0] wd,
                              output logic [31:0] rd, output logic [NC-1:0] exp_claim,
                              output logic [NC-1:0] exp_cmpl);
        int wa, off, c, w, r;
        wa = int'(addr >> 2);
        rd = '0; exp_claim = '0; exp_cmpl = '0;
        if (wa < 'h800) begin
            if (wa != 0 && wa < NS) begin
                if (wr) prio_m[wa] = wd[PW-1:0];
                else rd = 32'(prio_m[wa]);
            end
        end else if (wa < 'h80000) begin
            off = wa - 'h800; c = off >> 5; w = off & 31;
            if (c < NC && w < NW) begin
                if (wr) en_m[c][w] = wd & word_mask(w);
                else rd = en_m[c][w];
            end
        end else begin
            off = wa - 'h80000; c = off >> 10; r = off & 1023;
            if (c < NC) begin
                if (r == 0) begin
                    if (wr) begin
                        if (wd[PW-1:0] <= MAXP) thr_m[c] = wd[PW-1:0];
                    end else rd = 32'(thr_m[c]);
                end else if (r == 1) begin
                    if (wr) exp_cmpl[c] = 1'b1;
                    else begin
                        exp_claim[c] = 1'b1;
                        rd = 32'(claim_id[c*IW +: IW]);
                    end
                end
            end
        end
    endtask

    task automatic access(input bit wr, input logic [23:0] addr, input logic [31:0] wd,
                          input string req);
        logic [31:0] rd;
        logic [NC-1:0] ec, ep;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        ref_access(wr, addr, wd, rd, ec, ep);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "rsp_valid", 256'(rsp_valid), 256'(1));
        chk(req, "rdata", 256'(rsp_rdata), 256'(rd));
        chk(req, "claim_rd", 256'(claim_rd), 256'(ec));
        chk(req, "complete_wr", 256'(complete_wr), 256'(ep));
        if (ep != '0) chk("R8", "complete_id", 256'(complete_id), 256'(wd[IW-1:0]));
        chk(req, "prio_flat", 256'(prio_flat), prio_exp());
        chk(req, "enable_flat", 256'(enable_flat), en_exp());
        chk(req, "thresh_flat", 256'(thresh_flat), thr_exp());
    endtask

    function automatic logic [23:0] rand_addr();
        int k;
        logic [23:0] a;
        k = $urandom_range(0, 4);
        case (k)
            0: a = 24'($urandom_range(0, NS + 3) * 4);
            1: a = 24'('h2000 + $urandom_range(0, NC) * 'h80 + $urandom_range(0, NW) * 4);
            2: a = 24'('h200000 + $urandom_range(0, NC) * 'h1000 + $urandom_range(0, 2) * 4);
            3: a = 24'('h1000 + $urandom_range(0, 255) * 4);
            default: a = 24'($urandom);
        endcase
        return a | 24'($urandom_range(0, 3));
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < NS; s++) prio_m[s] = '0;
        for (int c = 0; c < NC; c++) begin
            thr_m[c] = '0;
            for (int w = 0; w < NW; w++) en_m[c][w] = '0;
        end
        claim_id = {6'd33, 6'd17, 6'd5};
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "prio_flat", 256'(prio_flat), 256'(0));
        chk("R1", "enable_flat", 256'(enable_flat), 256'(0));
        chk("R1", "thresh_flat", 256'(thresh_flat), 256'(0));
        chk("R1", "strobes", 256'({claim_rd, complete_wr, rsp_valid}), 256'(0));
        chk("R12", "req_ready", 256'(req_ready), 256'(1));

        access(1, 24'h000014, 32'h0000_003F, "R2");     // src 5 -> 0xF
        access(0, 24'h000014, 32'h0, "R2");
        access(1, 24'h00009C, 32'h0000_0006, "R2");     // src 39 (last)
        access(0, 24'h00009C, 32'h0, "R2");
        access(1, 24'h000000, 32'hFFFF_FFFF, "R3");     // src 0
        access(0, 24'h000000, 32'h0, "R3");
        access(1, 24'h0000A0, 32'h0000_0009, "R3");     // src 40 beyond
        access(0, 24'h0000A0, 32'h0, "R3");
        access(1, 24'h002000, 32'hFFFF_FFFF, "R5");     // ctx0 word0
        access(0, 24'h002000, 32'h0, "R5");
        access(1, 24'h002084, 32'hFFFF_FFFF, "R4");     // ctx1 word1, only 8 live bits
        access(0, 24'h002084, 32'h0, "R4");
        access(1, 24'h002008, 32'hFFFF_FFFF, "R11");    // word past the last
        access(0, 24'h002008, 32'h0, "R11");
        access(1, 24'h202000, 32'h0000_0013, "R6");     // masked 3, accepted
        access(1, 24'h202000, 32'h0000_001F, "R6");     // masked 0xF, rejected
        access(1, 24'h202000, 32'h0000_0008, "R6");     // 8 > 7, rejected
        access(0, 24'h202000, 32'h0, "R6");
        access(1, 24'h200000, 32'h0000_0007, "R6");     // MAX_PRIO accepted
        access(0, 24'h202004, 32'h0, "R7");             // claim ctx2
        access(0, 24'h200004, 32'h0, "R7");             // claim ctx0
        access(1, 24'h201004, 32'h0000_0FE7, "R8");     // complete ctx1 id 0x27
        access(1, 24'h203000, 32'h0000_0002, "R9");     // ctx 3 threshold
        access(0, 24'h203004, 32'h0, "R9");             // ctx 3 claim
        access(1, 24'h002180, 32'hFFFF_FFFF, "R9");     // ctx 3 enable
        access(1, 24'h00001B, 32'h0000_0004, "R10");    // src 6 with low bits set
        access(0, 24'h000019, 32'h0, "R10");
        access(0, 24'h201006, 32'h0, "R10");            // claim ctx1 with low bits
        access(1, 24'h001004, 32'hFFFF_FFFF, "R11");    // pending area
        access(0, 24'h001004, 32'h0, "R11");
        access(1, 24'h200008, 32'h0000_0001, "R11");    // unused context offset
        access(0, 24'h200008, 32'h0, "R11");
        @(negedge clk);
        chk("R12", "rsp_valid idle", 256'(rsp_valid), 256'(0));

        for (int i = 0; i < 400; i++) begin
            claim_id = NC*IW'($urandom);
            access(bit'($urandom_range(0, 1)), rand_addr(), $urandom, "R2_R4_R6_R7_R11");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule